// File: doc/BRIEF.md
# Windowed keyed watchdog timer

This block is a watchdog peripheral. A 12-bit down-counter is advanced by a
slow timebase. A free-running 7-bit prescaler divides that timebase by 128.
`slow_tick_i` is a one-cycle enable that marks each slow period in the fast
`clk` domain. Software configures the block once through a mode word. That word
sets:

- the reload value;
- a restart window bound;
- whether expiry drives the reset output;
- whether a debug request freezes counting;
- whether the watchdog is switched off.

Software restarts the counter with a keyed command write. A restart is honoured
only while the counter has fallen to the window bound or below. An early restart
is treated as a fault. When the counter expires, the block raises a sticky
expiry flag. When reset is enabled, it also drives a fixed-length reset pulse
toward the system reset controller.

Accesses use a small register port with three word offsets: command (0x0), mode
(0x4) and status (0x8). A write takes effect at the clock edge on which
`bus_wr_i` is high. Read data appears on `bus_rdata_o` after the edge on which
`bus_rd_i` is high. A read of any other offset returns zero.

Top module: `wdog_top`

## Requirements
- R1: After reset:
  - the mode word reads back with reload 0xFFF, window 0xFFF, reset enable 1, halt 0 and off 0;
  - status reads with count 0xFFF, expiry 0, early 0 and lock 0;
  - `wd_rst_o` and `fault_o` are low.
- R2: Mode word layout:
  - bits [11:0] hold the reload value;
  - bit 12 is reset enable;
  - bit 13 is debug halt;
  - bit 14 is off;
  - bits [27:16] hold the window bound;
  - all other bits read as zero.
- R3: The mode word accepts exactly one write after reset. That write sets the status lock bit (bit 2). Every later mode write is ignored, and the readback is unchanged.
- R4: The accepted mode write loads the counter with the new reload value and clears the prescaler.
- R5: While counting, the counter drops by one on every 128th slow tick. It expires on the 128th tick after reaching zero and then reloads. The first expiry after the mode write therefore falls on the (reload+1)*128-th slow tick.
- R6: Status layout:
  - bit 0 is the expiry flag;
  - bit 1 is the early-restart flag;
  - bit 2 is lock;
  - bits [27:16] hold the current count.

  An expiry sets bit 0. `fault_o` is high while bit 0 or bit 1 is set. A status read returns the flags and then clears both; a new event in the same cycle wins over the clear.
- R7: When reset enable is 1, an expiry drives `wd_rst_o` high for exactly 4 clock cycles, starting at the edge of the expiry. When reset enable is 0, `wd_rst_o` stays low.
- R8: With the off bit set, the counter neither counts nor expires, and restart commands are ignored.
- R9: With the halt bit set, while `dbg_i` is high, the counter and prescaler hold their values. With the halt bit clear, `dbg_i` has no effect.
- R10: A command write is a restart only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other command write has no effect.
- R11: A restart while the count is at or below the window bound reloads the counter and clears the prescaler. With the window bound at 0xFFF, every restart is accepted.
- R12: A restart while the count is above the window bound leaves the counter unchanged and sets the early flag. When reset enable is 1, it also starts the 4-cycle reset pulse at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle enable per slow timebase period |
| dbg_i | input | 1 | Debug request, level |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 4 | Word offset: 0x0 command, 0x4 mode, 0x8 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| wd_rst_o | output | 1 | Reset request pulse |
| fault_o | output | 1 | High while an expiry or early-restart flag is held |

## Verification
The properties assume that there is at most one write per cycle, so that a mode write and a restart never coincide. They also assume that `slow_tick_i` and `dbg_i` are synchronous levels sampled at the clock edge. The bench drives every input at the falling edge and issues one access per task call. Around any read whose count value it predicts, and around every restart it scores, the bench holds `slow_tick_i` low. This keeps the counter still, so the expected window outcome is fixed. The random trials pick the reload value, the window bound and the elapsed ticks so that the restart always lands before expiry.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    parameter int unsigned WD_CNT_W  = 12;
    parameter int unsigned WD_BUS_W  = 32;
    parameter int unsigned WD_ADDR_W = 4;
    parameter int unsigned WD_KEY_W  = 8;

    localparam logic [WD_ADDR_W-1:0] WD_A_CMD  = WD_ADDR_W'(4'h0);
    localparam logic [WD_ADDR_W-1:0] WD_A_MODE = WD_ADDR_W'(4'h4);
    localparam logic [WD_ADDR_W-1:0] WD_A_STAT = WD_ADDR_W'(4'h8);

    localparam logic [WD_KEY_W-1:0] WD_KEY = 8'hA5;
    localparam int unsigned WD_KEY_LSB     = WD_BUS_W - WD_KEY_W;
    localparam int unsigned WD_KICK_BIT    = 0;

    localparam int unsigned M_RELOAD_LSB = 0;
    localparam int unsigned M_RSTEN_BIT  = 12;
    localparam int unsigned M_HALT_BIT   = 13;
    localparam int unsigned M_OFF_BIT    = 14;
    localparam int unsigned M_WIN_LSB    = 16;

    localparam int unsigned S_EXP_BIT  = 0;
    localparam int unsigned S_EARLY_BIT = 1;
    localparam int unsigned S_LOCK_BIT = 2;
    localparam int unsigned S_CNT_LSB  = 16;

    typedef struct packed {
        logic [WD_CNT_W-1:0] window;
        logic                off;
        logic                halt;
        logic                rst_en;
        logic [WD_CNT_W-1:0] reload;
    } mode_t;

    localparam mode_t MODE_RST = '{
        window: {WD_CNT_W{1'b1}},
        off:    1'b0,
        halt:   1'b0,
        rst_en: 1'b1,
        reload: {WD_CNT_W{1'b1}}
    };

    function automatic mode_t mode_unpack(input logic [WD_BUS_W-1:0] w);
        mode_t m;
        m.reload = w[M_RELOAD_LSB +: WD_CNT_W];
        m.rst_en = w[M_RSTEN_BIT];
        m.halt   = w[M_HALT_BIT];
        m.off    = w[M_OFF_BIT];
        m.window = w[M_WIN_LSB +: WD_CNT_W];
        return m;
    endfunction

    function automatic logic [WD_BUS_W-1:0] mode_pack(input mode_t m);
        logic [WD_BUS_W-1:0] w;
        w = '0;
        w[M_RELOAD_LSB +: WD_CNT_W] = m.reload;
        w[M_RSTEN_BIT]              = m.rst_en;
        w[M_HALT_BIT]               = m.halt;
        w[M_OFF_BIT]                = m.off;
        w[M_WIN_LSB +: WD_CNT_W]    = m.window;
        return w;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [WD_ADDR_W-1:0] addr_i,
    input  logic [WD_BUS_W-1:0]  wdata_i,
    input  logic [WD_CNT_W-1:0]  cnt_i,
    input  logic                 exp_evt_i,
    input  logic                 early_evt_i,
    output logic [WD_BUS_W-1:0]  rdata_o,
    output mode_t                mode_o,
    output mode_t                mode_new_o,
    output logic                 mode_wr_o,
    output logic                 kick_req_o,
    output logic                 st_exp_o,
    output logic                 st_early_o,
    output logic                 locked_o
);

    typedef struct packed {
        mode_t                mode;
        logic                 locked;
        logic                 exp;
        logic                 early;
        logic [WD_BUS_W-1:0]  rdata;
    } regs_st_t;

    regs_st_t s_d, s_q;

    logic                stat_rd;
    logic [WD_BUS_W-1:0] stat_word;
    logic                key_ok;
    logic                unused_wbits;

    assign unused_wbits = ^wdata_i;

    always_comb begin
        s_d        = s_q;
        mode_new_o = mode_unpack(wdata_i);
        mode_wr_o  = wr_en_i && (addr_i == WD_A_MODE) && !s_q.locked;
        key_ok     = (wdata_i[WD_KEY_LSB +: WD_KEY_W] == WD_KEY);
        kick_req_o = wr_en_i && (addr_i == WD_A_CMD) && key_ok && wdata_i[WD_KICK_BIT];
        stat_rd    = rd_en_i && (addr_i == WD_A_STAT);

        stat_word                         = '0;
        stat_word[S_EXP_BIT]              = s_q.exp;
        stat_word[S_EARLY_BIT]            = s_q.early;
        stat_word[S_LOCK_BIT]             = s_q.locked;
        stat_word[S_CNT_LSB +: WD_CNT_W]  = cnt_i;

        if (mode_wr_o) begin
            s_d.mode   = mode_new_o;
            s_d.locked = 1'b1;
        end

        // Clear-on-read first, so a same-cycle event overrides it.
        if (stat_rd) begin
            s_d.exp   = 1'b0;
            s_d.early = 1'b0;
        end
        if (exp_evt_i) begin
            s_d.exp = 1'b1;
        end
        if (early_evt_i) begin
            s_d.early = 1'b1;
        end

        if (rd_en_i) begin
            case (addr_i)
                WD_A_MODE: s_d.rdata = mode_pack(s_q.mode);
                WD_A_STAT: s_d.rdata = stat_word;
                default:   s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode   <= MODE_RST;
            s_q.locked <= 1'b0;
            s_q.exp    <= 1'b0;
            s_q.early  <= 1'b0;
            s_q.rdata  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o    = s_q.rdata;
    assign mode_o     = s_q.mode;
    assign st_exp_o   = s_q.exp;
    assign st_early_o = s_q.early;
    assign locked_o   = s_q.locked;

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned PRESC_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_tick_i,
    input  logic                dbg_i,
    input  mode_t               mode_i,
    input  mode_t               mode_new_i,
    input  logic                mode_wr_i,
    input  logic                kick_req_i,
    output logic [WD_CNT_W-1:0] cnt_o,
    output logic [PRESC_W-1:0]  presc_o,
    output logic                exp_evt_o,
    output logic                early_evt_o
);

    localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};

    typedef struct packed {
        logic [WD_CNT_W-1:0] cnt;
        logic [PRESC_W-1:0]  presc;
    } core_st_t;

    core_st_t s_d, s_q;

    logic counting;
    logic step;
    logic wrap;
    logic in_window;
    logic kick_ok;

    always_comb begin
        s_d         = s_q;
        counting    = !mode_i.off && !(mode_i.halt && dbg_i);
        step        = counting && slow_tick_i;
        wrap        = step && (s_q.presc == PRESC_LAST);
        in_window   = (s_q.cnt <= mode_i.window);
        kick_ok     = kick_req_i && !mode_i.off && in_window;
        early_evt_o = kick_req_i && !mode_i.off && !in_window;
        exp_evt_o   = wrap && (s_q.cnt == '0) && !kick_ok && !mode_wr_i;

        if (mode_wr_i) begin
            s_d.cnt   = mode_new_i.reload;
            s_d.presc = '0;
        end else if (kick_ok) begin
            s_d.cnt   = mode_i.reload;
            s_d.presc = '0;
        end else if (step) begin
            s_d.presc = s_q.presc + 1'b1;
            if (wrap) begin
                s_d.cnt = (s_q.cnt == '0) ? mode_i.reload : (s_q.cnt - 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= MODE_RST.reload;
            s_q.presc <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o   = s_q.cnt;
    assign presc_o = s_q.presc;

endmodule

// File: rtl/wdog_rstgen.sv
`timescale 1ns/1ps
module wdog_rstgen #(
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic rst_o
);

    localparam int unsigned CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);

    typedef struct packed {
        logic [CW-1:0] left;
    } gen_st_t;

    gen_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire_i) begin
            s_d.left = FULL;
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_o = (s_q.left != '0);

endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned PRESC_W   = 7,
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_tick_i,
    input  logic                 dbg_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [WD_ADDR_W-1:0] bus_addr_i,
    input  logic [WD_BUS_W-1:0]  bus_wdata_i,
    output logic [WD_BUS_W-1:0]  bus_rdata_o,
    output logic                 wd_rst_o,
    output logic                 fault_o
);

    mode_t               mode_q;
    mode_t               mode_new;
    logic                mode_wr;
    logic                kick_req;
    logic [WD_CNT_W-1:0] cnt_q;
    logic [PRESC_W-1:0]  presc_q;
    logic                exp_evt;
    logic                early_evt;
    logic                st_exp;
    logic                st_early;
    logic                locked;
    logic                fire;

    wdog_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (bus_wr_i),
        .rd_en_i     (bus_rd_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .cnt_i       (cnt_q),
        .exp_evt_i   (exp_evt),
        .early_evt_i (early_evt),
        .rdata_o     (bus_rdata_o),
        .mode_o      (mode_q),
        .mode_new_o  (mode_new),
        .mode_wr_o   (mode_wr),
        .kick_req_o  (kick_req),
        .st_exp_o    (st_exp),
        .st_early_o  (st_early),
        .locked_o    (locked)
    );

    wdog_core #(.PRESC_W(PRESC_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick_i),
        .dbg_i       (dbg_i),
        .mode_i      (mode_q),
        .mode_new_i  (mode_new),
        .mode_wr_i   (mode_wr),
        .kick_req_i  (kick_req),
        .cnt_o       (cnt_q),
        .presc_o     (presc_q),
        .exp_evt_o   (exp_evt),
        .early_evt_o (early_evt)
    );

    assign fire = mode_q.rst_en && (exp_evt || early_evt);

    wdog_rstgen #(.PULSE_CYC(PULSE_CYC)) u_rstgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .rst_o  (wd_rst_o)
    );

    assign fault_o = st_exp || st_early;

endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int unsigned PRESC_W = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dbg_i,
    input logic                 bus_wr_i,
    input logic [WD_ADDR_W-1:0] bus_addr_i,
    input logic [WD_BUS_W-1:0]  bus_wdata_i,
    input logic                 wd_rst_o,
    input mode_t                mode_q,
    input logic                 locked,
    input logic [WD_CNT_W-1:0]  cnt_q,
    input logic [PRESC_W-1:0]   presc_q,
    input logic                 kick_req,
    input logic                 mode_wr,
    input logic                 exp_evt,
    input logic                 early_evt,
    input logic                 st_exp,
    input logic                 st_early
);

    a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode_q));

    a_r6_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exp_evt |=> st_exp);

    a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_evt && mode_q.rst_en) |=> wd_rst_o);

    a_r8_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.off |=> $stable(cnt_q));

    a_r9_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.halt && dbg_i && !kick_req && !mode_wr) |=> ($stable(cnt_q) && $stable(presc_q)));

    a_r10_bad_key_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == WD_A_CMD && bus_wdata_i[WD_KEY_LSB +: WD_KEY_W] != WD_KEY)
            |=> !$rose(st_early));

    a_r11_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_req && !mode_q.off && cnt_q <= mode_q.window) |=> (cnt_q == $past(mode_q.reload)));

    a_r12_early_flags: assert property (@(posedge clk) disable iff (!rst_n)
        early_evt |=> st_early);

endmodule

bind wdog_top wdog_chk #(.PRESC_W(PRESC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_i       (dbg_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .wd_rst_o    (wd_rst_o),
    .mode_q      (mode_q),
    .locked      (locked),
    .cnt_q       (cnt_q),
    .presc_q     (presc_q),
    .kick_req    (kick_req),
    .mode_wr     (mode_wr),
    .exp_evt     (exp_evt),
    .early_evt   (early_evt),
    .st_exp      (st_exp),
    .st_early    (st_early)
);

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;

    localparam int unsigned DIV      = 128;
    localparam int unsigned MAX_CYC  = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick_i = 1'b0;
    logic        dbg_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        wd_rst_o;
    logic        fault_o;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick_i),
        .dbg_i       (dbg_i),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .wd_rst_o    (wd_rst_o),
        .fault_o     (fault_o)
    );

    function automatic logic [31:0] mode_word(input int reload, input int win,
                                              input bit en, input bit halt, input bit off);
        logic [31:0] w;
        w = '0;
        w[11:0]  = reload[11:0];
        w[12]    = en;
        w[13]    = halt;
        w[14]    = off;
        w[27:16] = win[11:0];
        return w;
    endfunction

    function automatic logic [31:0] cmd_word(input logic [7:0] key, input bit kick);
        return {key, 23'd0, kick};
    endfunction

    function automatic int count_after(input int reload, input int ticks);
        return reload - ticks / DIV;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk);
        #1;
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(posedge clk);
        #1;
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; slow_tick_i = 1'b0; dbg_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_edges(1);
    endtask

    task automatic window_trial(input int rl, input int win, input bit en, input int ticks);
        logic [31:0] st;
        int c;
        bit early;
        do_reset();
        slow_tick_i = 1'b1;
        bus_write(4'h4, mode_word(rl, win, en, 1'b0, 1'b0));
        wait_edges(ticks);
        slow_tick_i = 1'b0;
        c = count_after(rl, ticks);
        early = (c > win);
        bus_read(4'h8, st);
        check("R5 count before restart", {20'd0, st[27:16]}, c);
        bus_write(4'h0, cmd_word(8'hA5, 1'b1));
        check("R12 pulse on early restart", {31'd0, wd_rst_o}, {31'd0, early && en});
        bus_read(4'h8, st);
        if (early) begin
            check("R12 count unchanged", {20'd0, st[27:16]}, c);
            check("R12 early flag", {31'd0, st[1]}, 32'd1);
        end else begin
            check("R11 reload in window", {20'd0, st[27:16]}, rl);
            check("R11 no early flag", {31'd0, st[1]}, 32'd0);
        end
        wait_edges(6);
    endtask

    initial begin : watchdog
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        int seen;
        void'($urandom(32'h5EED_0A5C));

        // R1 reset state
        do_reset();
        check("R1 wd_rst_o low", {31'd0, wd_rst_o}, 32'd0);
        check("R1 fault_o low", {31'd0, fault_o}, 32'd0);
        bus_read(4'h4, rd);
        check("R1 R2 default mode", rd, mode_word(12'hFFF, 12'hFFF, 1'b1, 1'b0, 1'b0));
        bus_read(4'h8, rd);
        check("R1 default status", rd, {4'd0, 12'hFFF, 16'd0});
        bus_read(4'hC, rd);
        check("R1 unmapped reads zero", rd, 32'd0);

        // R2 R3 R4 write once
        bus_write(4'h4, mode_word(12'h123, 12'h456, 1'b0, 1'b1, 1'b0));
        bus_read(4'h4, rd);
        check("R2 mode readback", rd, mode_word(12'h123, 12'h456, 1'b0, 1'b1, 1'b0));
        bus_read(4'h8, rd);
        check("R4 reload on mode write", {20'd0, rd[27:16]}, 32'h123);
        check("R3 lock bit", {31'd0, rd[2]}, 32'd1);
        bus_write(4'h4, mode_word(12'h0AA, 12'h001, 1'b1, 1'b0, 1'b1));
        bus_read(4'h4, rd);
        check("R3 second write ignored", rd, mode_word(12'h123, 12'h456, 1'b0, 1'b1, 1'b0));
        bus_read(4'h8, rd);
        check("R3 count untouched", {20'd0, rd[27:16]}, 32'h123);

        // R5 R6 R7 expiry timing with reset enabled
        do_reset();
        slow_tick_i = 1'b1;
        bus_write(4'h4, mode_word(3, 12'hFFF, 1'b1, 1'b0, 1'b0));
        wait_edges((3 + 1) * DIV - 1);
        check("R5 no expiry before timeout", {31'd0, wd_rst_o}, 32'd0);
        wait_edges(1);
        check("R7 pulse at expiry", {31'd0, wd_rst_o}, 32'd1);
        wait_edges(3);
        check("R7 pulse still high at 4th cycle", {31'd0, wd_rst_o}, 32'd1);
        wait_edges(1);
        check("R7 pulse ends after 4 cycles", {31'd0, wd_rst_o}, 32'd0);
        check("R6 fault raised", {31'd0, fault_o}, 32'd1);
        slow_tick_i = 1'b0;
        bus_read(4'h8, rd);
        check("R6 expiry flag", {31'd0, rd[0]}, 32'd1);
        check("R5 reloaded after expiry", {20'd0, rd[27:16]}, 32'd3);
        check("R6 fault cleared by read", {31'd0, fault_o}, 32'd0);
        bus_read(4'h8, rd);
        check("R6 flag cleared on read", {31'd0, rd[0]}, 32'd0);

        // R7 reset disabled
        do_reset();
        slow_tick_i = 1'b1;
        bus_write(4'h4, mode_word(1, 12'hFFF, 1'b0, 1'b0, 1'b0));
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            wait_edges(1);
            if (wd_rst_o) seen++;
        end
        slow_tick_i = 1'b0;
        check("R7 no pulse when disabled", seen, 0);
        bus_read(4'h8, rd);
        check("R6 expiry flag without pulse", {31'd0, rd[0]}, 32'd1);

        // R8 off
        do_reset();
        slow_tick_i = 1'b1;
        bus_write(4'h4, mode_word(2, 0, 1'b1, 1'b0, 1'b1));
        seen = 0;
        for (int i = 0; i < 600; i++) begin
            wait_edges(1);
            if (wd_rst_o) seen++;
        end
        slow_tick_i = 1'b0;
        check("R8 no pulse when off", seen, 0);
        bus_write(4'h0, cmd_word(8'hA5, 1'b1));
        bus_read(4'h8, rd);
        check("R8 count frozen", {20'd0, rd[27:16]}, 32'd2);
        check("R8 no expiry", {31'd0, rd[0]}, 32'd0);
        check("R8 restart ignored", {31'd0, rd[1]}, 32'd0);

        // R9 halt, R10 key, R11 prescaler clear
        do_reset();
        dbg_i = 1'b1;
        slow_tick_i = 1'b1;
        bus_write(4'h4, mode_word(5, 12'hFFF, 1'b0, 1'b1, 1'b0));
        wait_edges(1000);
        slow_tick_i = 1'b0;
        bus_read(4'h8, rd);
        check("R9 halted count", {20'd0, rd[27:16]}, 32'd5);
        dbg_i = 1'b0;
        slow_tick_i = 1'b1;
        wait_edges(DIV);
        slow_tick_i = 1'b0;
        bus_read(4'h8, rd);
        check("R9 counts after release", {20'd0, rd[27:16]}, 32'd4);
        bus_write(4'h0, cmd_word(8'h5A, 1'b1));
        bus_read(4'h8, rd);
        check("R10 wrong key ignored", {20'd0, rd[27:16]}, 32'd4);
        bus_write(4'h0, cmd_word(8'hA5, 1'b0));
        bus_read(4'h8, rd);
        check("R10 missing restart bit ignored", {20'd0, rd[27:16]}, 32'd4);
        slow_tick_i = 1'b1;
        wait_edges(50);
        slow_tick_i = 1'b0;
        bus_write(4'h0, cmd_word(8'hA5, 1'b1));
        bus_read(4'h8, rd);
        check("R11 restart with full window", {20'd0, rd[27:16]}, 32'd5);
        slow_tick_i = 1'b1;
        wait_edges(DIV - 1);
        slow_tick_i = 1'b0;
        bus_read(4'h8, rd);
        check("R11 prescaler cleared", {20'd0, rd[27:16]}, 32'd5);
        slow_tick_i = 1'b1;
        wait_edges(1);
        slow_tick_i = 1'b0;
        bus_read(4'h8, rd);
        check("R11 decrement after full period", {20'd0, rd[27:16]}, 32'd4);

        // R11 R12 window boundaries and random trials
        window_trial(4, 2, 1'b1, 2 * DIV);
        window_trial(4, 2, 1'b1, 1 * DIV);
        window_trial(4, 2, 1'b0, 1 * DIV + 7);
        for (int t = 0; t < 20; t++) begin
            int rl;
            int win;
            int ticks;
            bit en;
            rl    = 2 + int'($urandom % 19);
            win   = int'($urandom % (rl + 1));
            ticks = int'($urandom % (DIV * rl));
            en    = bit'($urandom % 2);
            window_trial(rl, win, en, ticks);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule